// File: doc/BRIEF.md
# UART FIFO Trigger Threshold and Request Logic

This block turns the per-direction trigger configuration of a UART into numeric FIFO thresholds. It compares those thresholds with the live occupancy counts of the transmit and receive FIFOs, and drives level-style service requests toward an interrupt or DMA controller. The transmit side asks for service while enough free space is available. The receive side asks for service while enough characters are waiting. When DMA mode is on, the receive side instead requests once for each character that arrives.

Each direction picks one of three threshold encodings. The choice depends on a granularity bit and on whether the 4-bit fine field is zero:

- **Table lookup:** the 2-bit coarse field indexes a small table.
- **Steps of four:** the threshold is four times the fine field.
- **Exact 6-bit value:** the fine field forms the upper bits and the coarse field the lower bits.

A zero exact value cannot be used. The block reports it as a configuration error and holds the request low.

Each direction has its own request state machine. The states are:

- `ST_BELOW`: no request.
- `ST_MET`: the level condition holds.
- `ST_BYTE`: a character arrived while in DMA mode.
- `ST_CFG_BAD`: the configuration is unusable.

On every clock the machine takes the transition selected by the current inputs:

- **To `ST_CFG_BAD`:** taken from any state when the configuration is invalid.
- **To `ST_BYTE`:** taken in DMA mode when the count has risen since the previous clock.
- **To `ST_MET`:** taken in level mode when the count is at or above the threshold.
- **To `ST_BELOW`:** taken in every other case.

Top module: `uart_fifo_trig`

## Requirements
- R1: With granularity 0 and fine field 0, the TX threshold is 8, 16, 32 or 56 for coarse codes 0, 1, 2 and 3.
- R2: With granularity 0 and fine field 0, the RX threshold is 8, 16, 56 or 60 for coarse codes 0, 1, 2 and 3.
- R3: With granularity 0 and a nonzero fine field F, the threshold of that direction is 4×F (4 to 60).
- R4: With granularity 1, the threshold is fine×4 + coarse, i.e. the fine field in bits 5:2 and the coarse field in bits 1:0 (1 to 63).
- R5: With granularity 1 and both fields zero, the direction's config-error output is 1, its threshold output is 0 and its request is 0, whatever the count.
- R6: The TX request is 1 exactly when the free-space count is greater than or equal to the TX threshold. DMA mode does not change this.
- R7: With DMA mode off, the RX request is 1 exactly when the fill count is greater than or equal to the RX threshold.
- R8: With DMA mode on, the RX request is 1 for the cycle after each clock at which the fill count is higher than on the previous clock. It is 0 otherwise, even when the count is above the threshold.
- R9: Every output reflects the inputs sampled at the most recent rising clock edge. A config or count change is therefore seen one edge later, and the outputs hold steady between edges.
- R10: During reset and until the first edge after it, both thresholds, both requests and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_mode | input | 1 | RX requests once per received character when 1 |
| tx_gran | input | 1 | TX granularity select |
| tx_coarse | input | 2 | TX coarse field |
| tx_fine | input | 4 | TX fine field |
| rx_gran | input | 1 | RX granularity select |
| rx_coarse | input | 2 | RX coarse field |
| rx_fine | input | 4 | RX fine field |
| tx_free | input | 7 | TX FIFO free entries (0 to 64) |
| rx_fill | input | 7 | RX FIFO filled entries (0 to 64) |
| tx_thr | output | 6 | Computed TX threshold |
| rx_thr | output | 6 | Computed RX threshold |
| tx_req | output | 1 | TX space-available request |
| rx_req | output | 1 | RX data-available request |
| tx_cfg_err | output | 1 | TX configuration unusable |
| rx_cfg_err | output | 1 | RX configuration unusable |

## Verification
Every coarse code is applied in both directions, which separates the two lookup tables. Fine values of 1, 7 and 15 are applied with granularity 0, and exact values of 1, 22 and 63 with granularity 1; these distinguish shifting the fine field from concatenating it with the coarse field. Counts just below, at and above a threshold expose an off-by-one in the comparison. In DMA mode the fill count is rising, then steady above the threshold, then falling, which shows the per-character pulse is not the level rule. Sampling a request between edges after a config change confirms the one-edge latency.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
    localparam int COARSE_W = 2;
    localparam int FINE_W   = 4;
    localparam int THR_W    = COARSE_W + FINE_W;
    localparam int CNT_W    = THR_W + 1;

    typedef logic [THR_W-1:0] thr_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        ST_BELOW   = 2'd0,
        ST_MET     = 2'd1,
        ST_BYTE    = 2'd2,
        ST_CFG_BAD = 2'd3
    } req_state_t;
endpackage

// File: rtl/uart_trig_thr.sv
module uart_trig_thr
    import uart_trig_pkg::*;
#(
    parameter bit IS_RX = 1'b0
) (
    input  logic                gran,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [FINE_W-1:0]   fine,
    output thr_t                thr,
    output logic                bad
);
    thr_t table_val;

    // Lookup table differs per direction
    generate
        if (IS_RX) begin : g_rx_table
            always_comb begin
                unique case (coarse)
                    2'd0:    table_val = thr_t'(8);
                    2'd1:    table_val = thr_t'(16);
                    2'd2:    table_val = thr_t'(56);
                    default: table_val = thr_t'(60);
                endcase
            end
        end else begin : g_tx_table
            always_comb begin
                unique case (coarse)
                    2'd0:    table_val = thr_t'(8);
                    2'd1:    table_val = thr_t'(16);
                    2'd2:    table_val = thr_t'(32);
                    default: table_val = thr_t'(56);
                endcase
            end
        end
    endgenerate

    always_comb begin
        bad = 1'b0;
        if (gran) begin
            thr = {fine, coarse};
            bad = (fine == '0) && (coarse == '0);
        end else if (fine != '0) begin
            thr = {fine, {COARSE_W{1'b0}}};
        end else begin
            thr = table_val;
        end
    end
endmodule

// File: rtl/uart_trig_req_fsm.sv
module uart_trig_req_fsm
    import uart_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode,
    input  thr_t thr_nxt,
    input  logic bad,
    input  cnt_t cnt,
    output thr_t thr,
    output logic req,
    output logic err
);
    req_state_t state_q, state_d;
    cnt_t       prev_q;
    thr_t       thr_q;

    // Next-state selection
    always_comb begin
        if (bad)
            state_d = ST_CFG_BAD;
        else if (pulse_mode)
            state_d = (cnt > prev_q) ? ST_BYTE : ST_BELOW;
        else if (cnt >= CNT_W'(thr_nxt))
            state_d = ST_MET;
        else
            state_d = ST_BELOW;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BELOW;
            prev_q  <= '0;
            thr_q   <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= cnt;
            thr_q   <= bad ? '0 : thr_nxt;
        end
    end

    // Outputs decoded from state
    always_comb begin
        req = 1'b0;
        err = 1'b0;
        unique case (state_q)
            ST_BELOW:   ;
            ST_MET:     req = 1'b1;
            ST_BYTE:    req = 1'b1;
            ST_CFG_BAD: err = 1'b1;
            default:    ;
        endcase
    end

    assign thr = thr_q;

    // R6 R7
    lvl_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && !bad && cnt >= CNT_W'(thr_nxt)) |=> req);

    // R6 R7
    lvl_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && !bad && cnt < CNT_W'(thr_nxt)) |=> !req);

    // R8
    byte_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && !bad && cnt <= prev_q) |=> !req);

    // R5
    cfg_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> (err && !req && thr == '0));

    // R3 R4
    thr_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |=> (thr != '0 && !err));
endmodule

// File: rtl/uart_fifo_trig.sv
module uart_fifo_trig
    import uart_trig_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dma_mode,
    input  logic                tx_gran,
    input  logic [COARSE_W-1:0] tx_coarse,
    input  logic [FINE_W-1:0]   tx_fine,
    input  logic                rx_gran,
    input  logic [COARSE_W-1:0] rx_coarse,
    input  logic [FINE_W-1:0]   rx_fine,
    input  logic [CNT_W-1:0]    tx_free,
    input  logic [CNT_W-1:0]    rx_fill,
    output logic [THR_W-1:0]    tx_thr,
    output logic [THR_W-1:0]    rx_thr,
    output logic                tx_req,
    output logic                rx_req,
    output logic                tx_cfg_err,
    output logic                rx_cfg_err
);
    thr_t tx_thr_nxt, rx_thr_nxt;
    logic tx_bad, rx_bad;

    uart_trig_thr #(.IS_RX(1'b0)) u_tx_thr (
        .gran(tx_gran), .coarse(tx_coarse), .fine(tx_fine),
        .thr(tx_thr_nxt), .bad(tx_bad)
    );

    uart_trig_thr #(.IS_RX(1'b1)) u_rx_thr (
        .gran(rx_gran), .coarse(rx_coarse), .fine(rx_fine),
        .thr(rx_thr_nxt), .bad(rx_bad)
    );

    uart_trig_req_fsm u_tx_fsm (
        .clk(clk), .rst_n(rst_n), .pulse_mode(1'b0),
        .thr_nxt(tx_thr_nxt), .bad(tx_bad), .cnt(tx_free),
        .thr(tx_thr), .req(tx_req), .err(tx_cfg_err)
    );

    uart_trig_req_fsm u_rx_fsm (
        .clk(clk), .rst_n(rst_n), .pulse_mode(dma_mode),
        .thr_nxt(rx_thr_nxt), .bad(rx_bad), .cnt(rx_fill),
        .thr(rx_thr), .req(rx_req), .err(rx_cfg_err)
    );

    // R5
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req && tx_cfg_err) && !(rx_req && rx_cfg_err));
endmodule

// File: tb/uart_fifo_trig_tb.sv
module uart_fifo_trig_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_mode = 1'b0;
    logic       tx_gran = 1'b0, rx_gran = 1'b0;
    logic [1:0] tx_coarse = '0, rx_coarse = '0;
    logic [3:0] tx_fine = '0, rx_fine = '0;
    logic [6:0] tx_free = '0, rx_fill = '0;
    logic [5:0] tx_thr, rx_thr;
    logic       tx_req, rx_req, tx_cfg_err, rx_cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_trig u_dut (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
        .tx_gran(tx_gran), .tx_coarse(tx_coarse), .tx_fine(tx_fine),
        .rx_gran(rx_gran), .rx_coarse(rx_coarse), .rx_fine(rx_fine),
        .tx_free(tx_free), .rx_fill(rx_fill),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_req(tx_req), .rx_req(rx_req),
        .tx_cfg_err(tx_cfg_err), .rx_cfg_err(rx_cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        step();
        chk("R10 tx_thr", tx_thr, 0);
        chk("R10 rx_thr", rx_thr, 0);
        chk("R10 reqs", {tx_req, rx_req}, 0);
        chk("R10 errs", {tx_cfg_err, rx_cfg_err}, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_coarse();
        int tx_tab[4] = '{8, 16, 32, 56};
        int rx_tab[4] = '{8, 16, 56, 60};
        tx_gran = 0; rx_gran = 0; tx_fine = 0; rx_fine = 0;
        for (int i = 0; i < 4; i++) begin
            tx_coarse = 2'(i); rx_coarse = 2'(i);
            step();
            chk("R1 tx table", tx_thr, tx_tab[i]);
            chk("R2 rx table", rx_thr, rx_tab[i]);
        end
    endtask

    task automatic t_fine();
        int vals[3] = '{1, 7, 15};
        tx_gran = 0; rx_gran = 0; tx_coarse = 2'd3; rx_coarse = 2'd2;
        for (int i = 0; i < 3; i++) begin
            tx_fine = 4'(vals[i]); rx_fine = 4'(vals[i]);
            step();
            chk("R3 tx step4", tx_thr, 4 * vals[i]);
            chk("R3 rx step4", rx_thr, 4 * vals[i]);
        end
    endtask

    task automatic t_exact();
        tx_gran = 1; rx_gran = 1;
        tx_fine = 0; tx_coarse = 1; rx_fine = 15; rx_coarse = 3;
        step();
        chk("R4 tx exact 1", tx_thr, 1);
        chk("R4 rx exact 63", rx_thr, 63);
        tx_fine = 5; tx_coarse = 2; rx_fine = 5; rx_coarse = 2;
        step();
        chk("R4 tx exact 22", tx_thr, 22);
        chk("R4 rx exact 22", rx_thr, 22);
    endtask

    task automatic t_bad();
        tx_gran = 1; rx_gran = 1; tx_fine = 0; tx_coarse = 0;
        rx_fine = 0; rx_coarse = 0; tx_free = 64; rx_fill = 64;
        step();
        chk("R5 tx err", tx_cfg_err, 1);
        chk("R5 tx thr", tx_thr, 0);
        chk("R5 tx req", tx_req, 0);
        chk("R5 rx err", rx_cfg_err, 1);
        chk("R5 rx req", rx_req, 0);
        tx_coarse = 1;
        step();
        chk("R5 tx err clears", tx_cfg_err, 0);
        chk("R5 tx req after clear", tx_req, 1);
    endtask

    task automatic t_level();
        dma_mode = 0;
        tx_gran = 0; tx_fine = 4; rx_gran = 0; rx_fine = 4;
        tx_free = 15; rx_fill = 15;
        step();
        chk("R6 tx below", tx_req, 0);
        chk("R7 rx below", rx_req, 0);
        tx_free = 16; rx_fill = 16;
        step();
        chk("R6 tx equal", tx_req, 1);
        chk("R7 rx equal", rx_req, 1);
        tx_free = 64; rx_fill = 64;
        step();
        chk("R6 tx full", tx_req, 1);
        chk("R7 rx full", rx_req, 1);
    endtask

    task automatic t_dma();
        rx_gran = 0; rx_fine = 0; rx_coarse = 0;
        tx_gran = 0; tx_fine = 4; tx_free = 20;
        rx_fill = 5;
        step();
        dma_mode = 1; rx_fill = 20;
        step();
        chk("R8 rise pulses", rx_req, 1);
        chk("R6 tx unaffected by dma", tx_req, 1);
        step();
        chk("R8 steady above thr", rx_req, 0);
        rx_fill = 21;
        step();
        chk("R8 next byte", rx_req, 1);
        rx_fill = 10;
        step();
        chk("R8 fall", rx_req, 0);
        dma_mode = 0;
        step();
        chk("R7 level restored", rx_req, 1);
    endtask

    task automatic t_latency();
        rx_gran = 0; rx_fine = 4; rx_fill = 20;
        step();
        chk("R9 base", rx_req, 1);
        rx_fine = 8;
        #1;
        chk("R9 held before edge", rx_req, 1);
        chk("R9 thr held", rx_thr, 16);
        step();
        chk("R9 after edge req", rx_req, 0);
        chk("R9 after edge thr", rx_thr, 32);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_coarse();
        t_fine();
        t_exact();
        t_bad();
        t_level();
        t_dma();
        t_latency();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule